// File: doc/BRIEF.md
# Parallel ATA PIO Register-Cycle Engine

This block runs single 16-bit programmed-I/O cycles on a parallel ATA bus on behalf of a host. Software programs a device address, a transmit word, per-phase clock counts and a transfer length through a small register bus. It then sets a start bit with a direction flag. The engine drives the chip selects, the three device address lines, the read and write strobes and the data bus. When readiness checking is enabled, it stretches the strobe while the device holds IORDY low. It reports completion through a sticky status flag that software clears by writing a one.

Each cycle has three phases: address setup, strobe asserted, and recovery. Every phase has its own programmed length. The data port (address 0) uses the data-transfer timing words. Addresses 1 to 15 use the register-transfer timing word for the strobe and recovery phases. The engine also drives the bus reset line from a control bit. It latches the device interrupt line into the same write-one-to-clear status register, and a mask decides which status bits raise the host interrupt.

Register map on `reg_addr`: 0 control/status (write: bit0 start, bit1 direction with 1 = write, bit2 IORDY enable, bit3 device reset; read: bit0 busy, bit2, bit3), 1 device address [3:0], 2 transmit word, 3 receive word (read only), 4 transfer length, 5 interrupt status (bit0 done, bit1 device interrupt), 6 interrupt mask (bits 1:0), 7 register timing ([7:0] recovery, [15:8] strobe), 8 data timing A ([7:0] setup, [15:8] recovery), 9 data timing B ([7:0] strobe, [15:8] write hold).

Top module: `pata_pio_engine`

## Requirements
- R1: After a synchronous reset the chip selects and both strobes are inactive (high), the data output enable is low, the bus reset line is high, host_irq is low, and every readable register returns 0.
- R2: A start with control bit1 = 1 runs a write cycle. The latched transmit word is driven on ata_dout with ata_dout_en high while ata_diow_n is low, and the device receives that word.
- R3: A start with bit1 = 0 runs a read cycle on ata_dior_n. The receive register loads ata_din only on the last clock of the asserted strobe and changes at no other time.
- R4: Device address bit3 = 1 asserts ata_cs1_n and bit3 = 0 asserts ata_cs0_n. Bits [2:0] appear on ata_da for the whole cycle, and exactly one select is low while a strobe is low.
- R5: A cycle is setup for t1 clocks, then strobe for teoc clocks, then recovery for max(t2, t4) clocks, where a programmed count of 0 acts as 1 for t1, teoc and t2. The two strobes are never low together.
- R6: Address 0 takes strobe and recovery counts from the data timing words. Addresses 1 to 15 take them from the register timing word. Setup and write hold always come from the data timing words.
- R7: On writes, ata_dout_en stays high for exactly t4 clocks after the strobe is released (0 means it drops with the strobe).
- R8: With control bit2 set, the strobe phase cannot end while ata_iordy is low. With bit2 clear, ata_iordy has no effect.
- R9: Status bit0 is set in the clock after the last recovery clock and stays set until a 1 is written to it. Control bit0 reads as busy while a cycle runs.
- R10: A start written while busy is ignored: the running cycle keeps its address, direction and data, and no extra cycle follows.
- R11: A transfer length N runs N back-to-back cycles (0 acts as 1), and the done flag is set only after the last one.
- R12: Control bit3 holds ata_reset_n low for as long as it stays set.
- R13: A high ata_intrq sets status bit1, which is cleared by writing 1 to it. host_irq is high exactly when a status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Write data to the bus |
| ata_dout_en | output | 1 | Data bus output enable |
| ata_din | input | 16 | Read data from the bus |
| ata_iordy | input | 1 | Device ready, synchronous to clk |
| ata_intrq | input | 1 | Device interrupt request, synchronous to clk |
| ata_reset_n | output | 1 | Bus reset line, active low |
| host_irq | output | 1 | Masked interrupt to the host |

## Verification
The bench targets phase lengths at their edges. All-zero timing must give one-clock phases, since a design that counted a zero down would hang for 256 clocks. A write hold longer than recovery must stretch the cycle, or the data would be dropped while the select is still active. It drives IORDY low across the point where the strobe would otherwise end. A design that ignores IORDY would end the strobe early, and one that ignores the enable bit would stretch it when it should not. It also issues a start in the middle of a long strobe and runs a three-word transfer. A design that re-arms on a busy start would produce a second strobe, and one that flags completion per word would raise done too early.

// File: rtl/pata_pio_pkg.sv
// Package: register offsets, control bit positions and the cycle phase
// type shared by the PIO engine, its submodules and its bench.
package pata_pio_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 4'd0;
    localparam logic [REG_AW-1:0] OFS_DADDR  = 4'd1;
    localparam logic [REG_AW-1:0] OFS_TX     = 4'd2;
    localparam logic [REG_AW-1:0] OFS_RX     = 4'd3;
    localparam logic [REG_AW-1:0] OFS_LEN    = 4'd4;
    localparam logic [REG_AW-1:0] OFS_STAT   = 4'd5;
    localparam logic [REG_AW-1:0] OFS_MASK   = 4'd6;
    localparam logic [REG_AW-1:0] OFS_REGTIM = 4'd7;
    localparam logic [REG_AW-1:0] OFS_DTIMA  = 4'd8;
    localparam logic [REG_AW-1:0] OFS_DTIMB  = 4'd9;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_IORDY = 2;
    localparam int CB_RST   = 3;

    localparam int SB_DONE  = 0;
    localparam int SB_DEV   = 1;
    localparam int STAT_W   = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_RECOV  = 2'd3
    } pio_phase_e;

endpackage

// File: rtl/pata_pio_regs.sv
// Register file of the PIO engine.
// Holds the software-visible configuration, the receive word and the
// sticky interrupt status. It produces the start request for the sequencer.
// Assumes ata_intrq is already synchronous to clk.
module pata_pio_regs
    import pata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              cycle_done,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              intrq,
    output logic              start_req,
    output logic              start_dir,
    output logic              iordy_en,
    output logic              dev_rst,
    output logic [3:0]        dev_addr,
    output logic [DATA_W-1:0] txbuf,
    output logic [DATA_W-1:0] xfer_len,
    output logic [CNT_W-1:0]  t1,
    output logic [CNT_W-1:0]  t4,
    output logic [CNT_W-1:0]  teoc_reg,
    output logic [CNT_W-1:0]  t2_reg,
    output logic [CNT_W-1:0]  teoc_dat,
    output logic [CNT_W-1:0]  t2_dat,
    output logic              irq
);

    logic [DATA_W-1:0] rxbuf;
    logic [DATA_W-1:0] regtim, dtim_a, dtim_b;
    logic [STAT_W-1:0] status, mask;
    logic              wr_ctrl, wr_stat;
    logic [STAT_W-1:0] clr_bits;

    assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == OFS_STAT);
    assign clr_bits  = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
    assign start_req = wr_ctrl && reg_wdata[CB_START];
    assign start_dir = reg_wdata[CB_DIR];

    assign t2_reg   = regtim[CNT_W-1:0];
    assign teoc_reg = regtim[2*CNT_W-1:CNT_W];
    assign t1       = dtim_a[CNT_W-1:0];
    assign t2_dat   = dtim_a[2*CNT_W-1:CNT_W];
    assign teoc_dat = dtim_b[CNT_W-1:0];
    assign t4       = dtim_b[2*CNT_W-1:CNT_W];

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iordy_en <= 1'b0;
            dev_rst  <= 1'b0;
            dev_addr <= '0;
            txbuf    <= '0;
            xfer_len <= '0;
            mask     <= '0;
            regtim   <= '0;
            dtim_a   <= '0;
            dtim_b   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL: begin
                    iordy_en <= reg_wdata[CB_IORDY];
                    dev_rst  <= reg_wdata[CB_RST];
                end
                OFS_DADDR:  dev_addr <= reg_wdata[3:0];
                OFS_TX:     txbuf    <= reg_wdata;
                OFS_LEN:    xfer_len <= reg_wdata;
                OFS_MASK:   mask     <= reg_wdata[STAT_W-1:0];
                OFS_REGTIM: regtim   <= reg_wdata;
                OFS_DTIMA:  dtim_a   <= reg_wdata;
                OFS_DTIMB:  dtim_b   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Receive word, loaded only at the read sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n)       rxbuf <= '0;
        else if (rx_load) rxbuf <= rx_data;
    end

    // Sticky status: a new event wins over a same-clock clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status[SB_DONE] <= (status[SB_DONE] & ~clr_bits[SB_DONE]) | cycle_done;
            status[SB_DEV]  <= (status[SB_DEV]  & ~clr_bits[SB_DEV])  | intrq;
        end
    end

    // Masked host interrupt.
    assign irq = |(status & mask);

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CB_START] = busy;
                reg_rdata[CB_IORDY] = iordy_en;
                reg_rdata[CB_RST]   = dev_rst;
            end
            OFS_DADDR:  reg_rdata[3:0] = dev_addr;
            OFS_TX:     reg_rdata = txbuf;
            OFS_RX:     reg_rdata = rxbuf;
            OFS_LEN:    reg_rdata = xfer_len;
            OFS_STAT:   reg_rdata[STAT_W-1:0] = status;
            OFS_MASK:   reg_rdata[STAT_W-1:0] = mask;
            OFS_REGTIM: reg_rdata = regtim;
            OFS_DTIMA:  reg_rdata = dtim_a;
            OFS_DTIMB:  reg_rdata = dtim_b;
            default:    reg_rdata = '0;
        endcase
    end

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_DONE] && !clr_bits[SB_DONE]) |=> status[SB_DONE]);

    assert_rx_only_at_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_load |=> $stable(rxbuf));

    assert_devint_latched_R13: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |=> status[SB_DEV]);

endmodule

// File: rtl/pata_pio_seq.sv
// Phase sequencer of the PIO engine.
// Runs setup, strobe and recovery phases with one down-counter, repeats
// them for the transfer length, and decodes the bus pins from the phase.
// Timing inputs are read at each phase entry and must not change during
// a cycle. ata_iordy is assumed synchronous to clk.
module pata_pio_seq
    import pata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              start_dir,
    input  logic [3:0]        dev_addr,
    input  logic [DATA_W-1:0] txbuf,
    input  logic [DATA_W-1:0] xfer_len,
    input  logic [CNT_W-1:0]  t1,
    input  logic [CNT_W-1:0]  t4,
    input  logic [CNT_W-1:0]  teoc_reg,
    input  logic [CNT_W-1:0]  t2_reg,
    input  logic [CNT_W-1:0]  teoc_dat,
    input  logic [CNT_W-1:0]  t2_dat,
    input  logic              iordy_en,
    input  logic              iordy,
    output logic              busy,
    output logic              cycle_done,
    output logic              rx_load,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);

    pio_phase_e        ph;
    logic [CNT_W-1:0]  cnt, hcnt;
    logic [DATA_W-1:0] rem;
    logic              dir_w;
    logic [3:0]        lat_addr;
    logic              data_port, ready;
    logic [CNT_W-1:0]  teoc_sel, t2_sel, t2_eff, rec_len;

    // Count minus one, with a programmed zero acting as one.
    function automatic logic [CNT_W-1:0] m1(input logic [CNT_W-1:0] x);
        return (x == '0) ? '0 : x - 1'b1;
    endfunction

    // Timing selection: the data port uses the data words, others the register word.
    always_comb begin
        data_port = (lat_addr == 4'd0);
        teoc_sel  = data_port ? teoc_dat : teoc_reg;
        t2_sel    = data_port ? t2_dat   : t2_reg;
        t2_eff    = (t2_sel == '0) ? CNT_W'(1) : t2_sel;
        rec_len   = (t4 > t2_eff) ? t4 : t2_eff;
        ready     = !iordy_en || iordy;
    end

    // Phase state machine with its phase, hold and remaining-cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            hcnt     <= '0;
            rem      <= '0;
            dir_w    <= 1'b0;
            lat_addr <= '0;
            dout     <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start_req) begin
                    ph       <= PH_SETUP;
                    cnt      <= m1(t1);
                    rem      <= (xfer_len == '0) ? '0 : xfer_len - 1'b1;
                    dir_w    <= start_dir;
                    lat_addr <= dev_addr;
                    dout     <= txbuf;
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_STROBE;
                        cnt <= m1(teoc_sel);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (ready) begin
                        ph   <= PH_RECOV;
                        cnt  <= rec_len - 1'b1;
                        hcnt <= t4;
                    end
                end
                PH_RECOV: begin
                    if (hcnt != '0) hcnt <= hcnt - 1'b1;
                    if (cnt == '0) begin
                        if (rem != '0) begin
                            rem <= rem - 1'b1;
                            ph  <= PH_SETUP;
                            cnt <= m1(t1);
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Event pulses toward the register file.
    assign busy       = (ph != PH_IDLE);
    assign cycle_done = (ph == PH_RECOV) && (cnt == '0) && (rem == '0);
    assign rx_load    = (ph == PH_STROBE) && (cnt == '0) && ready && !dir_w;

    // Bus pin decode from the current phase.
    always_comb begin
        cs0_n  = !(busy && !lat_addr[3]);
        cs1_n  = !(busy &&  lat_addr[3]);
        da     = busy ? lat_addr[2:0] : 3'd0;
        dior_n = !((ph == PH_STROBE) && !dir_w);
        diow_n = !((ph == PH_STROBE) &&  dir_w);
        doe    = dir_w && ((ph == PH_SETUP) || (ph == PH_STROBE) ||
                           ((ph == PH_RECOV) && (hcnt != '0)));
    end

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    assert_strobe_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> ($countones({cs0_n, cs1_n}) == 1));

    assert_iordy_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STROBE && iordy_en && !iordy) |=> (ph == PH_STROBE));

    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> ($stable(lat_addr) && $stable(dir_w) && $stable(dout)));

endmodule

// File: rtl/pata_pio_engine.sv
// Top of the parallel ATA PIO register-cycle engine.
// Joins the register file and the phase sequencer; the bus reset line
// follows the reset control bit directly.
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_dout_en,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy,
    input  logic              ata_intrq,
    output logic              ata_reset_n,
    output logic              host_irq
);

    localparam int CNT_W = DATA_W / 2;

    logic              busy, cycle_done, rx_load, start_req, start_dir;
    logic              iordy_en, dev_rst;
    logic [3:0]        dev_addr;
    logic [DATA_W-1:0] txbuf, xfer_len;
    logic [CNT_W-1:0]  t1, t4, teoc_reg, t2_reg, teoc_dat, t2_dat;

    pata_pio_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .cycle_done(cycle_done), .rx_load(rx_load),
        .rx_data(ata_din), .intrq(ata_intrq),
        .start_req(start_req), .start_dir(start_dir),
        .iordy_en(iordy_en), .dev_rst(dev_rst),
        .dev_addr(dev_addr), .txbuf(txbuf), .xfer_len(xfer_len),
        .t1(t1), .t4(t4), .teoc_reg(teoc_reg), .t2_reg(t2_reg),
        .teoc_dat(teoc_dat), .t2_dat(t2_dat),
        .irq(host_irq)
    );

    pata_pio_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .start_dir(start_dir),
        .dev_addr(dev_addr), .txbuf(txbuf), .xfer_len(xfer_len),
        .t1(t1), .t4(t4), .teoc_reg(teoc_reg), .t2_reg(t2_reg),
        .teoc_dat(teoc_dat), .t2_dat(t2_dat),
        .iordy_en(iordy_en), .iordy(ata_iordy),
        .busy(busy), .cycle_done(cycle_done), .rx_load(rx_load),
        .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n), .da(ata_da),
        .dior_n(ata_dior_n), .diow_n(ata_diow_n),
        .dout(ata_dout), .doe(ata_dout_en)
    );

    // Bus reset follows the control bit for as long as it is set.
    assign ata_reset_n = !dev_rst;

endmodule

// File: tb/pata_pio_engine_bench.sv
// Bench: behavioural per-clock reference model plus a register-file device.
module pata_pio_engine_bench;
    import pata_pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dout_en;
    logic [2:0]  ata_da;
    logic [15:0] ata_dout, ata_din;
    logic        ata_iordy = 1'b1;
    logic        ata_intrq = 1'b0;
    logic        ata_reset_n, host_irq;

    always #5 clk = ~clk;

    pata_pio_engine u_pata_pio_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_dout(ata_dout), .ata_dout_en(ata_dout_en), .ata_din(ata_din),
        .ata_iordy(ata_iordy), .ata_intrq(ata_intrq),
        .ata_reset_n(ata_reset_n), .host_irq(host_irq)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // ---------------- device model: 16-word register file ----------------
    logic [15:0] devreg [16];
    int          dev_idx;
    logic [15:0] pend_data;
    int          pend_idx;
    logic        prev_diow = 1'b1;

    assign dev_idx = {!ata_cs1_n, ata_da};
    assign ata_din = (!ata_dior_n) ? devreg[dev_idx] : 16'h0000;

    // ---------------- reference model state ----------------
    int          m_ph, m_cnt, m_hc, m_rem;
    logic        m_dir, m_ior, m_rst;
    logic [3:0]  m_addr, m_lad;
    logic [15:0] m_tx, m_ltx, m_len, m_rx, m_rt, m_pa, m_pb;
    logic [1:0]  m_stat, m_mask;
    logic [15:0] din_q;
    logic        cmp_on = 1'b0;

    function automatic int eff(input logic [7:0] x);
        return (x == 0) ? 1 : int'(x);
    endfunction

    // Reference model: advances one clock with the inputs seen before the edge.
    always @(posedge clk) begin
        int teoc_s, t2_s, t4v, rec;
        logic set_done;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_hc = 0; m_rem = 0;
            m_dir = 0; m_ior = 0; m_rst = 0; m_addr = 0; m_lad = 0;
            m_tx = 0; m_ltx = 0; m_len = 0; m_rx = 0; m_rt = 0; m_pa = 0; m_pb = 0;
            m_stat = 0; m_mask = 0;
        end else begin
            set_done = 0;
            teoc_s = (m_lad == 0) ? eff(m_pb[7:0]) : eff(m_rt[15:8]);
            t2_s   = (m_lad == 0) ? eff(m_pa[15:8]) : eff(m_rt[7:0]);
            t4v    = int'(m_pb[15:8]);
            rec    = (t4v > t2_s) ? t4v : t2_s;
            case (m_ph)
                0: if (reg_wr && reg_addr == OFS_CTRL && reg_wdata[0]) begin
                    m_dir = reg_wdata[1]; m_lad = m_addr; m_ltx = m_tx;
                    m_rem = (m_len == 0) ? 1 : int'(m_len);
                    m_ph = 1; m_cnt = eff(m_pa[7:0]);
                end
                1: if (m_cnt > 1) m_cnt--; else begin m_ph = 2; m_cnt = teoc_s; end
                2: if (m_cnt > 1) m_cnt--;
                   else if (!(m_ior && !ata_iordy)) begin
                       if (!m_dir) m_rx = din_q;
                       m_ph = 3; m_hc = t4v; m_cnt = rec;
                   end
                default: begin
                    if (m_hc > 0) m_hc--;
                    if (m_cnt > 1) m_cnt--;
                    else if (m_rem > 1) begin m_rem--; m_ph = 1; m_cnt = eff(m_pa[7:0]); end
                    else begin m_ph = 0; set_done = 1; end
                end
            endcase
            if (reg_wr && reg_addr == OFS_STAT) m_stat = m_stat & ~reg_wdata[1:0];
            if (set_done)  m_stat[0] = 1'b1;
            if (ata_intrq) m_stat[1] = 1'b1;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CTRL:   begin m_ior = reg_wdata[2]; m_rst = reg_wdata[3]; end
                    OFS_DADDR:  m_addr = reg_wdata[3:0];
                    OFS_TX:     m_tx = reg_wdata;
                    OFS_LEN:    m_len = reg_wdata;
                    OFS_MASK:   m_mask = reg_wdata[1:0];
                    OFS_REGTIM: m_rt = reg_wdata;
                    OFS_DTIMA:  m_pa = reg_wdata;
                    OFS_DTIMB:  m_pb = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- phase monitor ----------------
    int  mon_set, mon_stb, mon_rec, mon_hold, last_set, last_stb, last_rec, last_hold;
    int  strobe_total = 0;
    logic seen = 0, prev_act = 0, prev_stb = 0;

    // Per-clock: device, monitor and comparison with the reference model.
    always @(negedge clk) begin
        logic act, stb;
        din_q = ata_din;
        act = !ata_cs0_n || !ata_cs1_n;
        stb = !ata_dior_n || !ata_diow_n;
        if (!ata_diow_n) begin pend_data = ata_dout; pend_idx = dev_idx; end
        if (!prev_diow && ata_diow_n) devreg[pend_idx] = pend_data;
        prev_diow = ata_diow_n;
        if (act) begin
            if (stb) begin
                if (!prev_stb) strobe_total++;
                mon_stb++; seen = 1;
            end else if (!seen) mon_set++;
            else begin mon_rec++; if (ata_dout_en) mon_hold++; end
        end else if (prev_act) begin
            last_set = mon_set; last_stb = mon_stb; last_rec = mon_rec; last_hold = mon_hold;
            mon_set = 0; mon_stb = 0; mon_rec = 0; mon_hold = 0; seen = 0;
        end
        prev_act = act; prev_stb = stb;
        if (cmp_on) begin
            chk("R4", "cs0_n", ata_cs0_n, !(m_ph != 0 && !m_lad[3]));
            chk("R4", "cs1_n", ata_cs1_n, !(m_ph != 0 && m_lad[3]));
            chk("R4", "da", ata_da, (m_ph != 0) ? m_lad[2:0] : 3'd0);
            chk("R5", "dior_n", ata_dior_n, !(m_ph == 2 && !m_dir));
            chk("R5", "diow_n", ata_diow_n, !(m_ph == 2 && m_dir));
            chk("R7", "dout_en", ata_dout_en,
                m_dir && (m_ph == 1 || m_ph == 2 || (m_ph == 3 && m_hc > 0)));
            if (ata_dout_en) chk("R2", "dout", ata_dout, m_ltx);
            chk("R12", "reset_n", ata_reset_n, !m_rst);
            chk("R13", "host_irq", host_irq, |(m_stat & m_mask));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(OFS_CTRL, v);
            if (!v[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input logic [3:0] a, input logic [15:0] d, input logic [15:0] ctl);
        wr(OFS_DADDR, {12'd0, a});
        wr(OFS_TX, d);
        wr(OFS_CTRL, ctl);
        wait_idle();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 16; i++) devreg[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "strobes/selects", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}, 4'hF);
        chk("R1", "dout_en", ata_dout_en, 1'b0);
        chk("R1", "reset_n", ata_reset_n, 1'b1);
        chk("R1", "host_irq", host_irq, 1'b0);
        rd(OFS_STAT, v); chk("R1", "status", v, 16'h0);
        rd(OFS_RX, v);   chk("R1", "rxbuf", v, 16'h0);
        rd(OFS_CTRL, v); chk("R1", "ctrl", v, 16'h0);
        cmp_on = 1'b1;

        // Timing: setup 3, data recov 6, data strobe 5, hold 1, reg strobe 4, reg recov 2
        wr(OFS_DTIMA, 16'h0603);
        wr(OFS_DTIMB, 16'h0105);
        wr(OFS_REGTIM, 16'h0402);

        // R2 / R5 / R7: register write to address 1
        run(4'd1, 16'hA5C3, 16'h0003);
        chk("R2", "device word 1", devreg[1], 16'hA5C3);
        chk("R5", "setup clocks", last_set, 3);
        chk("R5", "strobe clocks", last_stb, 4);
        chk("R5", "recovery clocks", last_rec, 2);
        chk("R7", "hold clocks", last_hold, 1);

        // R4: control-block address 9 -> CS1, DA 1
        run(4'd9, 16'h1234, 16'h0003);
        chk("R4", "device word 9", devreg[9], 16'h1234);

        // R6: data port uses data timing
        run(4'd0, 16'hBEEF, 16'h0003);
        chk("R6", "device word 0", devreg[0], 16'hBEEF);
        chk("R6", "data strobe clocks", last_stb, 5);
        chk("R6", "data recovery clocks", last_rec, 6);

        // R3: reads
        run(4'd1, 16'h0000, 16'h0001);
        rd(OFS_RX, v); chk("R3", "read word 1", v, 16'hA5C3);
        run(4'd9, 16'h0000, 16'h0001);
        rd(OFS_RX, v); chk("R3", "read word 9", v, 16'h1234);

        // R9: sticky done, write-one-to-clear
        rd(OFS_STAT, v); chk("R9", "done set", v[0], 1'b1);
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, v); chk("R9", "done kept on write 0", v[0], 1'b1);
        wr(OFS_STAT, 16'h0001);
        rd(OFS_STAT, v); chk("R9", "done cleared", v[0], 1'b0);

        // R5: zero counts act as one
        wr(OFS_DTIMA, 16'h0000); wr(OFS_DTIMB, 16'h0000); wr(OFS_REGTIM, 16'h0000);
        run(4'd2, 16'h5A5A, 16'h0003);
        chk("R5", "zero setup", last_set, 1);
        chk("R5", "zero strobe", last_stb, 1);
        chk("R5", "zero recovery", last_rec, 1);
        chk("R7", "zero hold", last_hold, 0);
        chk("R2", "device word 2", devreg[2], 16'h5A5A);

        // R7: hold longer than recovery stretches the cycle
        wr(OFS_DTIMA, 16'h0603); wr(OFS_DTIMB, 16'h0405); wr(OFS_REGTIM, 16'h0402);
        run(4'd3, 16'hC0DE, 16'h0003);
        chk("R7", "long hold", last_hold, 4);
        chk("R7", "recovery = hold", last_rec, 4);

        // R8: IORDY stretch when enabled
        devreg[4] = 16'h7777;
        wr(OFS_DADDR, 16'd4);
        wr(OFS_CTRL, 16'h0005);
        while (ata_dior_n) @(negedge clk);
        ata_iordy = 1'b0;
        repeat (6) @(negedge clk);
        ata_iordy = 1'b1;
        wait_idle();
        chk("R8", "stretched strobe", last_stb, 7);
        rd(OFS_RX, v); chk("R8", "stretched read data", v, 16'h7777);
        // R8: ignored when disabled
        wr(OFS_CTRL, 16'h0001);
        while (ata_dior_n) @(negedge clk);
        ata_iordy = 1'b0;
        repeat (6) @(negedge clk);
        ata_iordy = 1'b1;
        wait_idle();
        chk("R8", "unstretched strobe", last_stb, 4);

        // R10: start while busy is ignored
        wr(OFS_REGTIM, 16'h1402);
        wr(OFS_DADDR, 16'd5);
        wr(OFS_TX, 16'h0F0F);
        strobe_total = 0;
        wr(OFS_CTRL, 16'h0003);
        while (ata_diow_n) @(negedge clk);
        wr(OFS_DADDR, 16'd6);
        wr(OFS_CTRL, 16'h0001);
        wait_idle();
        chk("R10", "strobe count", strobe_total, 1);
        chk("R10", "device word 5", devreg[5], 16'h0F0F);
        rd(OFS_RX, v); chk("R10", "rx unchanged", v, 16'h7777);
        wr(OFS_STAT, 16'h0003);

        // R11: three back-to-back cycles, done only after the last
        wr(OFS_REGTIM, 16'h0402);
        wr(OFS_LEN, 16'd3);
        wr(OFS_DADDR, 16'd7);
        wr(OFS_TX, 16'h3C3C);
        strobe_total = 0;
        wr(OFS_CTRL, 16'h0003);
        while (strobe_total < 2) @(negedge clk);
        rd(OFS_STAT, v); chk("R11", "done not early", v[0], 1'b0);
        rd(OFS_CTRL, v); chk("R9", "busy mid transfer", v[0], 1'b1);
        wait_idle();
        chk("R11", "strobe count", strobe_total, 3);
        rd(OFS_STAT, v); chk("R11", "done after last", v[0], 1'b1);
        wr(OFS_LEN, 16'd0);

        // R12: bus reset follows the control bit
        wr(OFS_CTRL, 16'h0008);
        repeat (3) @(negedge clk);
        chk("R12", "reset asserted", ata_reset_n, 1'b0);
        wr(OFS_CTRL, 16'h0000);
        chk("R12", "reset released", ata_reset_n, 1'b1);

        // R13: device interrupt latch and mask
        wr(OFS_STAT, 16'h0003);
        ata_intrq = 1'b1; @(negedge clk); ata_intrq = 1'b0;
        repeat (2) @(negedge clk);
        rd(OFS_STAT, v); chk("R13", "devint latched", v[1], 1'b1);
        chk("R13", "irq masked off", host_irq, 1'b0);
        wr(OFS_MASK, 16'h0002);
        chk("R13", "irq on", host_irq, 1'b1);
        wr(OFS_STAT, 16'h0002);
        chk("R13", "irq cleared", host_irq, 1'b0);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule